// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

A 4-bit binary counter (modulo 16) that steps up or down depending on which of two strobe inputs rises. It has no direction bit. The block also takes a preset word, an active-low parallel load and an active-high master clear. Two active-low terminal-count outputs allow several stages to be chained. The carry output pulses low during the low phase of the up strobe while the count is at its maximum. The borrow output pulses low during the low phase of the down strobe while the count is zero. Because of this, one stage's terminal outputs can drive the next stage's strobes directly.

Everything runs on a single system clock. The strobes, load, clear and preset word pass through a two-flop synchronizer. Strobe rising edges are found by comparing each synchronized sample with the previous one. The count register then updates on the following system clock edge. A system reset (`rst_n`, synchronous, active low) puts the block in a known idle state. In that state both strobes are taken as high, so a strobe line that is held high through reset produces no count when reset is released.

Top module: `updn_counter`

## Requirements
- R1: The count wraps in both directions: 15 steps up to 0, and 0 steps down to 15.
- R2: A low-to-high change on `up_strobe` increments the count and one on `down_strobe` decrements it. A strobe change made between system clock edges shows up at `count` after the third following rising edge of `clk`.
- R3: While the synchronized `load_n` is low (with `clear` low), the synchronized `preset` word is copied into the count, and strobe edges are ignored. The same three-edge latency as R2 applies.
- R4: While the synchronized `clear` is high, the count is forced to 0. This takes priority over `load_n` and over both strobes.
- R5: `carry_n` is low only while the count is 15 and the synchronized `up_strobe` level is low; otherwise it is high. The strobe level reaches the output two clock edges after the pin changes.
- R6: `borrow_n` is low only while the count is 0 and the synchronized `down_strobe` level is low; otherwise it is high.
- R7: With `clear` low, `load_n` high and no strobe rising edge, the count holds its value.
- R8: If rising edges on both strobes are detected in the same clock cycle, the count holds.
- R9: Two stages chain as an 8-bit counter: the low stage's `carry_n` drives the high stage's `up_strobe`, and its `borrow_n` drives the high stage's `down_strobe`. Both strobes idle high.
- R10: During `rst_n` low, the count becomes 0 and both terminal outputs are high. A strobe held high through reset does not count when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| up_strobe | input | 1 | Rising edge counts up |
| down_strobe | input | 1 | Rising edge counts down |
| load_n | input | 1 | Active-low parallel load of `preset` |
| clear | input | 1 | Active-high master clear |
| preset | input | W (4) | Word copied in on load |
| count | output | W (4) | Current count |
| carry_n | output | 1 | Low at count 15 while the up strobe is low |
| borrow_n | output | 1 | Low at count 0 while the down strobe is low |

## Verification
The assertions assume that every input is stable for at least one full system clock period, so each level and edge passes through the synchronizer exactly once. The stepping checks are written against the synchronized samples, not the pins. The bench changes every input only on the falling clock edge, one whole cycle at a time. It holds load and clear for whole cycles and spaces chained strobe pulses three cycles low and three cycles high, so the downstream stage always sees a clean level after synchronization.

// File: rtl/updn_pkg.sv
// Package: shared types for the dual-strobe up/down counter.
// Assumes: nothing beyond IEEE 1800-2017.
package updn_pkg;

    // Action the count register takes on the next clock edge.
    typedef enum logic [2:0] {
        STEP_HOLD  = 3'd0,
        STEP_INC   = 3'd1,
        STEP_DEC   = 3'd2,
        STEP_LOAD  = 3'd3,
        STEP_CLEAR = 3'd4
    } step_e;

endpackage

// File: rtl/updn_sync.sv
// Module: updn_sync
// A multi-stage flop chain that brings a vector of asynchronous inputs into
// the clk domain. On reset every stage is loaded with RST_VAL.
// Assumes: each input bit is stable for at least one clk period.
module updn_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stg;

            // Single sampling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end

            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;

            // Shift the input through STAGES flops; index 0 samples the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/updn_step_decode.sv
// Module: updn_step_decode
// Finds rising edges on the synchronized strobes and turns them, together
// with clear and load, into one step command. Priority order: clear, load,
// then strobes. Coincident up and down edges cancel.
// Assumes: inputs are already synchronous to clk; strobes idle high after reset.
module updn_step_decode
    import updn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  up_s,
    input  logic  dn_s,
    input  logic  load_n_s,
    input  logic  clear_s,
    output logic  up_rise,
    output logic  dn_rise,
    output step_e step
);

    logic up_prev;
    logic dn_prev;

    // Remember last cycle's strobe levels; reset to high so no edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_prev <= 1'b1;
            dn_prev <= 1'b1;
        end else begin
            up_prev <= up_s;
            dn_prev <= dn_s;
        end
    end

    assign up_rise = up_s & ~up_prev;
    assign dn_rise = dn_s & ~dn_prev;

    // Prioritised selection of the next count action.
    always_comb begin
        if (clear_s)                 step = STEP_CLEAR;
        else if (!load_n_s)          step = STEP_LOAD;
        else if (up_rise && !dn_rise) step = STEP_INC;
        else if (dn_rise && !up_rise) step = STEP_DEC;
        else                         step = STEP_HOLD;
    end

endmodule

// File: rtl/updn_count_core.sv
// Module: updn_count_core
// The count register. Applies one step command per clk edge; arithmetic
// wraps naturally at the register width.
// Assumes: step is a registered-path decode of synchronized inputs.
module updn_count_core
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_e        step,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    // Update the count according to the decoded step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (step)
                STEP_CLEAR: count <= '0;
                STEP_LOAD:  count <= preset;
                STEP_INC:   count <= count + ONE;
                STEP_DEC:   count <= count - ONE;
                default:    count <= count;
            endcase
        end
    end

endmodule

// File: rtl/updn_term.sv
// Module: updn_term
// Active-low terminal-count outputs: carry at the all-ones count while the
// synchronized up strobe is low, borrow at zero while the down strobe is low.
// Assumes: count and strobe levels are both clk-synchronous.
module updn_term #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic         up_s,
    input  logic         dn_s,
    output logic         carry_n,
    output logic         borrow_n
);

    localparam logic [W-1:0] TOP = '1;

    // Gate the terminal states with the low phase of the matching strobe.
    always_comb begin
        carry_n  = ~((count == TOP) && !up_s);
        borrow_n = ~((count == '0)  && !dn_s);
    end

    // Carry and borrow need opposite count extremes, so never both low.
    AST_TC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> borrow_n);  // R5

endmodule

// File: rtl/updn_counter.sv
// Module: updn_counter (top)
// Dual-strobe presettable up/down counter. Synchronizes all control inputs
// and the preset word, detects strobe edges, updates the count and drives
// the chainable terminal-count outputs.
// Assumes: every input holds each value for at least one clk period.
module updn_counter
    import updn_pkg::*;
#(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_strobe,
    input  logic         down_strobe,
    input  logic         load_n,
    input  logic         clear,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         carry_n,
    output logic         borrow_n
);

    localparam int              SYNC_W   = W + 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1110, {W{1'b0}}};
    localparam logic [W-1:0]    ONE      = W'(1);

    logic [SYNC_W-1:0] sync_q;
    logic              up_s, dn_s, load_n_s, clear_s;
    logic [W-1:0]      preset_s;
    logic              up_rise, dn_rise;
    step_e             step;

    updn_sync #(.WIDTH(SYNC_W), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({up_strobe, down_strobe, load_n, clear, preset}),
        .q     (sync_q)
    );

    assign {up_s, dn_s, load_n_s, clear_s, preset_s} = sync_q;

    updn_step_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_s     (up_s),
        .dn_s     (dn_s),
        .load_n_s (load_n_s),
        .clear_s  (clear_s),
        .up_rise  (up_rise),
        .dn_rise  (dn_rise),
        .step     (step)
    );

    updn_count_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .preset (preset_s),
        .count  (count)
    );

    updn_term #(.W(W)) u_term (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .up_s     (up_s),
        .dn_s     (dn_s),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // Count behaviour checked against the synchronized controls.
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_s |=> (count == '0));  // R4
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && !load_n_s) |=> (count == $past(preset_s)));  // R3
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && load_n_s && up_rise && !dn_rise) |=> (count == $past(count) + ONE));  // R2
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && load_n_s && dn_rise && !up_rise) |=> (count == $past(count) - ONE));  // R2
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && load_n_s && up_rise && dn_rise) |=> $stable(count));  // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && load_n_s && !up_rise && !dn_rise) |=> $stable(count));  // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> ((count == '0) && carry_n && borrow_n));  // R10

endmodule

// File: tb/updn_counter_test.sv
// Bench: scoreboard. The driver task applies one input word per cycle and
// pushes the expected outputs into a queue; a monitor pops and compares them.
module updn_counter_test;

    typedef struct packed {
        logic       up;
        logic       dn;
        logic       ld_n;
        logic       clr;
        logic [3:0] pre;
    } word_t;

    typedef struct {
        int         due;
        logic [3:0] cnt;
        logic       cy;
        logic       bw;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_strobe, down_strobe, load_n, clear;
    logic [3:0] preset;
    logic [3:0] count, count_hi;
    logic       carry_n, borrow_n, carry_hi_n, borrow_hi_n;

    int    tests = 0;
    int    fails = 0;
    int    cyc   = 0;
    string tag   = "R10";
    exp_t  q[$];
    word_t wprev;
    logic [3:0] c2;

    localparam word_t IDLE = '{up: 1'b1, dn: 1'b1, ld_n: 1'b1, clr: 1'b0, pre: 4'h0};

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    updn_counter uut (
        .clk(clk), .rst_n(rst_n), .up_strobe(up_strobe), .down_strobe(down_strobe),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    // Upper stage for the chaining check (R9).
    updn_counter uut_hi (
        .clk(clk), .rst_n(rst_n), .up_strobe(carry_n), .down_strobe(borrow_n),
        .load_n(1'b1), .clear(clear), .preset(4'h0),
        .count(count_hi), .carry_n(carry_hi_n), .borrow_n(borrow_hi_n)
    );

    function automatic word_t mk(logic u, logic d, logic l, logic c, logic [3:0] p);
        word_t w;
        w.up = u; w.dn = d; w.ld_n = l; w.clr = c; w.pre = p;
        return w;
    endfunction

    task automatic check(bit ok, string t, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, act, expv);
        end
    endtask

    // Driver: apply one word, queue the outputs due two edges on, advance the model.
    task automatic drive(word_t w);
        exp_t e;
        logic [3:0] c3;
        logic ur, dr;
        @(negedge clk);
        rst_n = 1'b1;
        up_strobe = w.up; down_strobe = w.dn; load_n = w.ld_n; clear = w.clr; preset = w.pre;
        e.due = cyc + 2;
        e.cnt = c2;
        e.cy  = !((c2 == 4'hF) && !w.up);
        e.bw  = !((c2 == 4'h0) && !w.dn);
        e.tag = tag;
        q.push_back(e);
        ur = w.up && !wprev.up;
        dr = w.dn && !wprev.dn;
        if (w.clr)                c3 = 4'h0;
        else if (!w.ld_n)         c3 = w.pre;
        else if (ur && !dr)       c3 = c2 + 4'h1;
        else if (dr && !ur)       c3 = c2 - 4'h1;
        else                      c3 = c2;
        wprev = w;
        c2 = c3;
    endtask

    task automatic hold(word_t w, int n);
        for (int i = 0; i < n; i++) drive(w);
    endtask

    task automatic pulse_up(int n);
        for (int i = 0; i < n; i++) begin
            hold(mk(1'b0, 1'b1, 1'b1, 1'b0, 4'h0), 3);
            hold(IDLE, 3);
        end
    endtask

    task automatic pulse_dn(int n);
        for (int i = 0; i < n; i++) begin
            hold(mk(1'b1, 1'b0, 1'b1, 1'b0, 4'h0), 3);
            hold(IDLE, 3);
        end
    endtask

    // Monitor: compare outputs against the queued expectation due this cycle.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(count == e.cnt,    {e.tag, " count"},    count,    e.cnt);
            check(carry_n == e.cy,   {e.tag, " carry_n"},  carry_n,  e.cy);
            check(borrow_n == e.bw,  {e.tag, " borrow_n"}, borrow_n, e.bw);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        up_strobe = 1'b1; down_strobe = 1'b1; load_n = 1'b1; clear = 1'b0; preset = 4'h0;
        wprev = IDLE;
        c2 = 4'h0;
        repeat (4) @(negedge clk);
        // R10: reset state at the ports.
        check(count == 4'h0, "R10 reset count", count, 0);
        check(carry_n && borrow_n, "R10 reset terminals", {carry_n, borrow_n}, 3);

        // R10: strobes high through reset release must not count.
        tag = "R10 release";
        hold(IDLE, 5);

        tag = "R3 load";
        drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 4'hD));
        hold(IDLE, 4);

        tag = "R1 wrap up";
        pulse_up(4);

        tag = "R5 carry";
        drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 4'hF));
        hold(IDLE, 3);
        hold(mk(1'b0, 1'b1, 1'b1, 1'b0, 4'h0), 5);
        hold(IDLE, 4);

        tag = "R6 borrow";
        drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 4'h0));
        hold(IDLE, 3);
        hold(mk(1'b1, 1'b0, 1'b1, 1'b0, 4'h0), 5);
        tag = "R1 wrap down";
        hold(IDLE, 4);

        tag = "R2 down";
        pulse_dn(3);

        tag = "R7 hold";
        hold(mk(1'b0, 1'b0, 1'b1, 1'b0, 4'h0), 6);

        tag = "R8 both";
        hold(mk(1'b1, 1'b1, 1'b1, 1'b0, 4'h0), 4);
        hold(mk(1'b0, 1'b0, 1'b1, 1'b0, 4'h0), 3);
        tag = "R3 load beats strobe";
        drive(mk(1'b1, 1'b0, 1'b0, 1'b0, 4'h6));
        hold(IDLE, 4);

        tag = "R4 clear priority";
        hold(mk(1'b0, 1'b1, 1'b1, 1'b0, 4'h0), 3);
        drive(mk(1'b1, 1'b1, 1'b0, 1'b1, 4'h9));
        hold(IDLE, 4);

        // R9: chained 8-bit counting.
        tag = "R9 chain";
        drive(mk(1'b1, 1'b1, 1'b1, 1'b1, 4'h0));
        hold(IDLE, 6);
        pulse_up(20);
        hold(IDLE, 8);
        check(count == 4'h4,    "R9 chain up low",  count,    4);
        check(count_hi == 4'h1, "R9 chain up high", count_hi, 1);
        pulse_dn(21);
        hold(IDLE, 8);
        check(count == 4'hF,    "R9 chain down low",  count,    15);
        check(count_hi == 4'hF, "R9 chain down high", count_hi, 15);

        // R2: randomized mix of strobes, loads and clears against the model.
        tag = "R2 random";
        for (int i = 0; i < 3000; i++) begin
            word_t w;
            w.up   = ($urandom_range(0, 3) != 0) ? wprev.up : ~wprev.up;
            w.dn   = ($urandom_range(0, 3) != 0) ? wprev.dn : ~wprev.dn;
            w.ld_n = ($urandom_range(0, 15) != 0);
            w.clr  = ($urandom_range(0, 31) == 0);
            w.pre  = 4'($urandom_range(0, 15));
            drive(w);
        end
        hold(IDLE, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule